// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This block resolves conditional jumps for a processor whose jump instructions compare two 32-bit values and, when the comparison holds, fetch the next instruction pointer from a dedicated jump-address register. The instruction carries no offset for the target. Each request presents a 4-bit condition code and a first register operand. It also presents a second operand, which is either a second register or a 16-bit immediate. The request also carries the jump-address register value and the current instruction pointer.

One clock edge after a request is strobed, the unit publishes its verdict: whether the jump is taken, and the next instruction pointer. That pointer is the jump-address value when the jump is taken, otherwise the current pointer advanced by one instruction word. The unit also reports whether the condition code is one it does not support, together with the exception vector for an invalid instruction. Register indices travel with the operand values so that index zero can be treated as the hard-wired zero register.

Top module: `jump_cond_unit`

## Requirements
- R1: Results appear on the cycle after `br_valid` is sampled high, with `res_valid` high for exactly that cycle. While no request is strobed, `res_valid` is low and `taken`, `next_ip`, `bad_cond` and `exc_vec` hold their last values.
- R2: Condition code 4'h0 always takes the jump, whatever the operand values.
- R3: Code 4'h1 takes the jump when the two operands differ. Code 4'h2 takes it when they are equal.
- R4: Code 4'h3 takes the jump when operand A is greater than operand B as unsigned numbers. Code 4'h4 takes it when A is greater than or equal to B as unsigned numbers.
- R5: Code 4'hC takes the jump when A is greater than B as two's-complement numbers. Code 4'hD takes it when A is greater than or equal to B as two's-complement numbers.
- R6: With `use_imm` high, operand B is the 16-bit `imm` sign-extended to 32 bits, for signed and unsigned codes alike. In that case `rs2_val` and `rs2_idx` have no effect.
- R7: An operand whose register index is 0 compares as zero, whatever value is presented for it. This applies to `rs1_idx`, and to `rs2_idx` in register form.
- R8: When the jump is taken, `next_ip` equals the `jump_addr` presented with the request.
- R9: When the jump is not taken, `next_ip` equals the presented `cur_ip` plus 1, modulo 2^32.
- R10: Codes 4'h5 to 4'hB, 4'hE and 4'hF are unsupported. They yield `taken`=0, `bad_cond`=1 and `exc_vec`=3. Supported codes yield `bad_cond`=0 and `exc_vec`=0.
- R11: While `rst` is high at a clock edge, `res_valid`, `taken` and `bad_cond` are cleared, and `next_ip` and `exc_vec` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Request strobe for one jump resolution |
| use_imm | input | 1 | 1: operand B from immediate; 0: from second register |
| cond | input | 4 | Jump condition code |
| rs1_idx | input | 4 | Register index of operand A |
| rs2_idx | input | 4 | Register index of operand B (register form) |
| rs1_val | input | 32 | Value read for operand A |
| rs2_val | input | 32 | Value read for operand B (register form) |
| imm | input | 16 | Immediate operand (immediate form) |
| jump_addr | input | 32 | Jump-address register value |
| cur_ip | input | 32 | Current instruction pointer |
| res_valid | output | 1 | Verdict valid this cycle |
| taken | output | 1 | Jump taken |
| next_ip | output | 32 | Next instruction pointer |
| bad_cond | output | 1 | Unsupported condition code |
| exc_vec | output | 5 | Exception vector (3 when `bad_cond`, else 0) |

## Verification
Every result of this unit (the taken flag, the next pointer, the invalid-code flag and its vector) is due exactly one clock edge after the request is sampled, because one register stage sits between inputs and outputs. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It then reads all outputs there, half a period after the capturing rising edge. A further idle cycle shows that the outputs hold while `res_valid` is low. A back-to-back pair of requests confirms that each verdict lands on its own cycle with no gap.

// File: rtl/jcu_pkg.sv
package jcu_pkg;

    // Supported comparison codes; every other 4-bit value is rejected.
    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_NE     = 4'h1,
        JC_EQ     = 4'h2,
        JC_UGT    = 4'h3,
        JC_UGE    = 4'h4,
        JC_SGT    = 4'hC,
        JC_SGE    = 4'hD
    } jcond_e;

    // Relations between operand A and operand B.
    typedef struct packed {
        logic eq;
        logic ugt;
        logic sgt;
    } cmp_flags_t;

    typedef struct packed {
        logic taken;
        logic bad;
    } verdict_t;

    function automatic verdict_t resolve(input logic [3:0] code, input cmp_flags_t f);
        verdict_t v;
        v = '{taken: 1'b0, bad: 1'b0};
        case (code)
            JC_ALWAYS: v.taken = 1'b1;
            JC_NE:     v.taken = ~f.eq;
            JC_EQ:     v.taken = f.eq;
            JC_UGT:    v.taken = f.ugt;
            JC_UGE:    v.taken = f.ugt | f.eq;
            JC_SGT:    v.taken = f.sgt;
            JC_SGE:    v.taken = f.sgt | f.eq;
            default:   v.bad   = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/jcu_operand_mux.sv
module jcu_operand_mux #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             use_imm,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  op_a,
    output logic [XLEN-1:0]  op_b
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            assign imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    // Index zero is the hard-wired zero register.
    always_comb begin
        op_a = (rs1_idx == '0) ? '0 : rs1_val;
        if (use_imm)
            op_b = imm_ext;
        else
            op_b = (rs2_idx == '0) ? '0 : rs2_val;
    end

endmodule

// File: rtl/jcu_compare.sv
module jcu_compare
    import jcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output cmp_flags_t      flags
);
    always_comb begin
        flags.eq  = (op_a == op_b);
        flags.ugt = (op_a > op_b);
        flags.sgt = ($signed(op_a) > $signed(op_b));
    end
endmodule

// File: rtl/jump_cond_unit.sv
module jump_cond_unit
    import jcu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int IDX_W   = 4,
    parameter int EXC_W   = 5,
    parameter int EXC_BAD = 3,
    parameter int IP_STEP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic             use_imm,
    input  logic [3:0]       cond,
    input  logic [IDX_W-1:0] rs1_idx,
    input  logic [IDX_W-1:0] rs2_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  jump_addr,
    input  logic [XLEN-1:0]  cur_ip,
    output logic             res_valid,
    output logic             taken,
    output logic [XLEN-1:0]  next_ip,
    output logic             bad_cond,
    output logic [EXC_W-1:0] exc_vec
);
    localparam logic [XLEN-1:0]  STEP_V = XLEN'(IP_STEP);
    localparam logic [EXC_W-1:0] BAD_V  = EXC_W'(EXC_BAD);

    logic [XLEN-1:0] op_a, op_b;
    cmp_flags_t      flags;
    verdict_t        vd;
    logic [XLEN-1:0] ip_sel;

    jcu_operand_mux #(
        .XLEN (XLEN),
        .IMM_W(IMM_W),
        .IDX_W(IDX_W)
    ) opmux_i (
        .use_imm(use_imm),
        .rs1_idx(rs1_idx),
        .rs2_idx(rs2_idx),
        .rs1_val(rs1_val),
        .rs2_val(rs2_val),
        .imm    (imm),
        .op_a   (op_a),
        .op_b   (op_b)
    );

    jcu_compare #(
        .XLEN(XLEN)
    ) cmp_i (
        .op_a (op_a),
        .op_b (op_b),
        .flags(flags)
    );

    always_comb begin
        vd     = resolve(cond, flags);
        ip_sel = vd.taken ? jump_addr : (cur_ip + STEP_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            next_ip   <= '0;
            bad_cond  <= 1'b0;
            exc_vec   <= '0;
        end else begin
            res_valid <= br_valid;
            if (br_valid) begin
                taken    <= vd.taken;
                next_ip  <= ip_sel;
                bad_cond <= vd.bad;
                exc_vec  <= vd.bad ? BAD_V : '0;
            end
        end
    end

endmodule

// File: rtl/jcu_checker.sv
module jcu_checker #(
    parameter int XLEN    = 32,
    parameter int EXC_W   = 5,
    parameter int EXC_BAD = 3,
    parameter int IP_STEP = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             br_valid,
    input logic [3:0]       cond,
    input logic [XLEN-1:0]  jump_addr,
    input logic [XLEN-1:0]  cur_ip,
    input logic             res_valid,
    input logic             taken,
    input logic [XLEN-1:0]  next_ip,
    input logic             bad_cond,
    input logic [EXC_W-1:0] exc_vec
);
    // R1: verdict is flagged exactly one edge after the strobe
    p_valid_timing_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(br_valid)));

    // R1: outputs hold while no request was strobed
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(br_valid)) |->
            ($stable(taken) && $stable(next_ip) && $stable(bad_cond) && $stable(exc_vec)));

    // R2: code zero is always taken
    p_always_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !$past(rst) && $past(cond) == 4'h0) |-> taken);

    // R8: taken jump targets the jump-address register
    p_target_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && taken && !$past(rst)) |-> (next_ip == $past(jump_addr)));

    // R9: fall-through advances the pointer by one word
    p_fallthru_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken && !$past(rst)) |->
            (next_ip == $past(cur_ip) + XLEN'(IP_STEP)));

    // R10: unsupported codes never jump and raise vector 3
    p_bad_not_taken_r10: assert property (@(posedge clk) disable iff (rst)
        bad_cond |-> (!taken && exc_vec == EXC_W'(EXC_BAD)));

    // R10: supported codes raise no vector
    p_no_vec_r10: assert property (@(posedge clk) disable iff (rst)
        !bad_cond |-> (exc_vec == '0));

endmodule

bind jump_cond_unit jcu_checker #(
    .XLEN   (XLEN),
    .EXC_W  (EXC_W),
    .EXC_BAD(EXC_BAD),
    .IP_STEP(IP_STEP)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .br_valid (br_valid),
    .cond     (cond),
    .jump_addr(jump_addr),
    .cur_ip   (cur_ip),
    .res_valid(res_valid),
    .taken    (taken),
    .next_ip  (next_ip),
    .bad_cond (bad_cond),
    .exc_vec  (exc_vec)
);

// File: tb/jump_cond_unit_tb_top.sv
`timescale 1ns/1ps
module jump_cond_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic        use_imm;
    logic [3:0]  cond;
    logic [3:0]  rs1_idx, rs2_idx;
    logic [31:0] rs1_val, rs2_val;
    logic [15:0] imm;
    logic [31:0] jump_addr, cur_ip;
    logic        res_valid, taken, bad_cond;
    logic [31:0] next_ip;
    logic [4:0]  exc_vec;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    jump_cond_unit dut_i (
        .clk(clk), .rst(rst), .br_valid(br_valid), .use_imm(use_imm),
        .cond(cond), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
        .jump_addr(jump_addr), .cur_ip(cur_ip),
        .res_valid(res_valid), .taken(taken), .next_ip(next_ip),
        .bad_cond(bad_cond), .exc_vec(exc_vec)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        im;
        logic [3:0]  code;
        logic [3:0]  i1;
        logic [3:0]  i2;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] k;
        logic        exp_t;
        logic        exp_bad;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VT [NV] = '{
        '{4'd2,  1'b0, 4'h0, 4'd1, 4'd2, 32'd5,        32'd9,        16'h0000, 1'b1, 1'b0}, // R2
        '{4'd3,  1'b0, 4'h1, 4'd1, 4'd2, 32'd5,        32'd5,        16'h0000, 1'b0, 1'b0}, // R3 ne, equal
        '{4'd3,  1'b0, 4'h1, 4'd1, 4'd2, 32'd5,        32'd6,        16'h0000, 1'b1, 1'b0}, // R3 ne, differ
        '{4'd3,  1'b0, 4'h2, 4'd1, 4'd2, 32'd7,        32'd7,        16'h0000, 1'b1, 1'b0}, // R3 eq
        '{4'd3,  1'b0, 4'h2, 4'd1, 4'd2, 32'd7,        32'd8,        16'h0000, 1'b0, 1'b0}, // R3 eq miss
        '{4'd4,  1'b0, 4'h3, 4'd1, 4'd2, 32'hFFFFFFFF, 32'd1,        16'h0000, 1'b1, 1'b0}, // R4 ugt
        '{4'd4,  1'b0, 4'h3, 4'd1, 4'd2, 32'd1,        32'd1,        16'h0000, 1'b0, 1'b0}, // R4 ugt equal
        '{4'd4,  1'b0, 4'h4, 4'd1, 4'd2, 32'd1,        32'd1,        16'h0000, 1'b1, 1'b0}, // R4 uge equal
        '{4'd4,  1'b0, 4'h4, 4'd1, 4'd2, 32'd0,        32'd1,        16'h0000, 1'b0, 1'b0}, // R4 uge less
        '{4'd5,  1'b0, 4'hC, 4'd1, 4'd2, 32'hFFFFFFFF, 32'd1,        16'h0000, 1'b0, 1'b0}, // R5 sgt -1>1
        '{4'd5,  1'b0, 4'hC, 4'd1, 4'd2, 32'd2,        32'hFFFFFFFE, 16'h0000, 1'b1, 1'b0}, // R5 sgt 2>-2
        '{4'd5,  1'b0, 4'hD, 4'd1, 4'd2, 32'hFFFFFFFB, 32'hFFFFFFFB, 16'h0000, 1'b1, 1'b0}, // R5 sge equal
        '{4'd5,  1'b0, 4'hD, 4'd1, 4'd2, 32'hFFFFFFFA, 32'hFFFFFFFB, 16'h0000, 1'b0, 1'b0}, // R5 sge less
        '{4'd6,  1'b1, 4'h2, 4'd1, 4'd2, 32'hFFFFFFFF, 32'd0,        16'hFFFF, 1'b1, 1'b0}, // R6 sign-ext eq
        '{4'd6,  1'b1, 4'h3, 4'd1, 4'd2, 32'h0000FFFF, 32'd0,        16'h8000, 1'b0, 1'b0}, // R6 unsigned vs ext
        '{4'd6,  1'b1, 4'hC, 4'd1, 4'd2, 32'd0,        32'd0,        16'hFFFF, 1'b1, 1'b0}, // R6 signed 0>-1
        '{4'd6,  1'b1, 4'hD, 4'd1, 4'd0, 32'd3,        32'd99,       16'h0003, 1'b1, 1'b0}, // R6 rs2 ignored
        '{4'd7,  1'b0, 4'h2, 4'd0, 4'd5, 32'd1234,     32'd0,        16'h0000, 1'b1, 1'b0}, // R7 rs1 idx 0
        '{4'd7,  1'b0, 4'h1, 4'd3, 4'd0, 32'd0,        32'd77,       16'h0000, 1'b0, 1'b0}, // R7 rs2 idx 0
        '{4'd7,  1'b1, 4'h2, 4'd0, 4'd2, 32'd50,       32'd0,        16'h0000, 1'b1, 1'b0}, // R7 imm form
        '{4'd10, 1'b0, 4'h5, 4'd1, 4'd2, 32'd4,        32'd4,        16'h0000, 1'b0, 1'b1}, // R10 code 5
        '{4'd10, 1'b0, 4'hE, 4'd1, 4'd2, 32'd9,        32'd1,        16'h0000, 1'b0, 1'b1}, // R10 code E
        '{4'd10, 1'b1, 4'hF, 4'd1, 4'd2, 32'd0,        32'd0,        16'h0000, 1'b0, 1'b1}, // R10 code F
        '{4'd10, 1'b0, 4'hB, 4'd1, 4'd2, 32'd3,        32'd3,        16'h0000, 1'b0, 1'b1}  // R10 code B
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic im, input logic [3:0] code,
                         input logic [3:0] i1, input logic [3:0] i2,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] k, input logic [31:0] ja,
                         input logic [31:0] ip);
        br_valid  = 1'b1;
        use_imm   = im;
        cond      = code;
        rs1_idx   = i1;
        rs2_idx   = i2;
        rs1_val   = a;
        rs2_val   = b;
        imm       = k;
        jump_addr = ja;
        cur_ip    = ip;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] ja, ip, exp_ip;
        string rq;
        rst = 1'b1;
        drive(1'b0, 4'h0, 4'd1, 4'd2, 32'd1, 32'd2, 16'h0, 32'hAAAA0000, 32'h55);
        br_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state, even with a request presented
        chk("R11", "res_valid", {31'd0, res_valid}, 32'd0);
        chk("R11", "taken",     {31'd0, taken},     32'd0);
        chk("R11", "next_ip",   next_ip,            32'd0);
        chk("R11", "bad_cond",  {31'd0, bad_cond},  32'd0);
        chk("R11", "exc_vec",   {27'd0, exc_vec},   32'd0);
        rst = 1'b0;
        br_valid = 1'b0;
        @(negedge clk);

        for (int n = 0; n < NV; n++) begin
            ja = 32'h8000_0000 | (n << 4);
            ip = 32'h0000_1000 + n * 8;
            rq = $sformatf("R%0d(vec%0d)", VT[n].req, n);
            drive(VT[n].im, VT[n].code, VT[n].i1, VT[n].i2, VT[n].a, VT[n].b, VT[n].k, ja, ip);
            @(negedge clk);
            br_valid = 1'b0;
            exp_ip = VT[n].exp_t ? ja : ip + 32'd1;   // R8 / R9
            chk(rq, "res_valid", {31'd0, res_valid}, 32'd1);
            chk(rq, "taken",     {31'd0, taken},     {31'd0, VT[n].exp_t});
            chk(rq, "bad_cond",  {31'd0, bad_cond},  {31'd0, VT[n].exp_bad});
            chk(rq, "exc_vec",   {27'd0, exc_vec},   VT[n].exp_bad ? 32'd3 : 32'd0);
            chk(VT[n].exp_t ? "R8" : "R9", "next_ip", next_ip, exp_ip);
            @(negedge clk);
            // R1: idle cycle, valid drops and outputs hold
            chk("R1", "res_valid idle", {31'd0, res_valid}, 32'd0);
            chk("R1", "next_ip hold",   next_ip,            exp_ip);
        end

        // R9: fall-through wraps at the top of the address space
        drive(1'b0, 4'h1, 4'd1, 4'd2, 32'd3, 32'd3, 16'h0, 32'h1234, 32'hFFFFFFFF);
        @(negedge clk);
        br_valid = 1'b0;
        chk("R9", "wrap next_ip", next_ip, 32'd0);
        chk("R9", "wrap taken", {31'd0, taken}, 32'd0);

        // R1: back-to-back requests, one verdict per cycle
        drive(1'b0, 4'h0, 4'd1, 4'd2, 32'd0, 32'd0, 16'h0, 32'h0000_7000, 32'h20);
        @(negedge clk);
        chk("R1", "b2b first valid", {31'd0, res_valid}, 32'd1);
        chk("R8", "b2b first next_ip", next_ip, 32'h0000_7000);
        drive(1'b0, 4'h2, 4'd1, 4'd2, 32'd1, 32'd2, 16'h0, 32'h0000_7100, 32'h21);
        @(negedge clk);
        br_valid = 1'b0;
        chk("R1", "b2b second valid", {31'd0, res_valid}, 32'd1);
        chk("R9", "b2b second next_ip", next_ip, 32'h22);
        @(negedge clk);
        chk("R1", "b2b idle", {31'd0, res_valid}, 32'd0);

        // R11: reset clears a held verdict
        drive(1'b0, 4'h7, 4'd1, 4'd2, 32'd0, 32'd0, 16'h0, 32'h1, 32'h2);
        @(negedge clk);
        br_valid = 1'b0;
        chk("R10", "bad before reset", {31'd0, bad_cond}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "bad after reset", {31'd0, bad_cond}, 32'd0);
        chk("R11", "exc after reset", {27'd0, exc_vec}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule